// File: doc/BRIEF.md
# Serial Interrupt Host Controller

This block is the host end of a single-wire serialized interrupt bus. The wire is shared and open-drain, so the block only ever pulls it low or lets it go. It sees the wire through a sampled input, `line_in`, and controls it through a pull-low enable, `line_oe`. Each serial interrupt cycle has three parts. A start pulse opens the cycle. A programmable run of three-clock interrupt frames follows, and the host reads one interrupt request in each frame. A stop pulse closes the cycle, and its width tells every agent whether the next cycle runs in Continuous or Quiet mode.

In Continuous mode the host opens every cycle itself. In Quiet mode the bus stays idle until a peripheral pulls the wire low for one clock. The host then stretches that pulse into a full start pulse and runs the cycle. Clearing the quiet request while the bus sits idle makes the host open a cycle on its own. That cycle ends with a wide stop, which puts the bus back into Continuous mode before the system configuration changes.

The sampled request levels are held in shadow storage during the cycle. They are moved to the output vector all at once when the stop pulse ends. A one-clock strobe marks that update.

Top module: `sirq_host`

## Requirements
- R1: While `rst` is high, `line_oe` is 0 from the first clock edge onward, `irq_level` is all zeros and `irq_valid` is 0. After reset the bus is in Continuous mode, so the host opens the first cycle by itself.
- R2: A cycle opened by the host holds `line_oe` at 1 for exactly 4 clocks. Call the first of these clock 0. No run of `line_oe` high is ever longer than 4 clocks.
- R3: After the start pulse come two released clocks, then the frames. Each frame is 3 clocks long. Request n is sampled at the end of clock 6+3n, counted from clock 0. A low wire sets bit n of `irq_level` to 1, meaning asserted, and a high wire sets it to 0.
- R4: The frame count is read from `frame_count` when a cycle opens. A value below 17 is raised to 17, and a value above MAX_FRAMES is lowered to MAX_FRAMES. Bits of `irq_level` at or above the frame count in use read 0.
- R5: The stop pulse begins at clock 6+3N, where N is the frame count in use, so it comes only after every frame has finished. It lasts 2 clocks if `quiet_mode` is 1 at the end of the last frame, and 3 clocks otherwise.
- R6: After a 3-clock stop, the host's next start pulse begins in the third clock after the wire is released. `line_oe` never rises in the clock right after it falls.
- R7: After a 2-clock stop, the host leaves the wire alone for as long as `quiet_mode` stays 1. A peripheral that pulls the wire low for one clock (clock 0) opens a cycle. The host then drives clocks 1 to 3, and the frames follow with the same timing as in R3.
- R8: If `quiet_mode` is cleared while the bus is idle in Quiet mode, the host opens a cycle itself with a 4-clock start pulse. That cycle ends with a 3-clock stop.
- R9: `irq_level` changes only in the clock in which `irq_valid` is 1. That clock is clock 6+3N+W, the first clock after a stop pulse of width W. `irq_valid` is high for a single clock per cycle.
- R10: With 17 frames and a host-opened cycle, the whole cycle from clock 0 up to the `irq_valid` clock takes at most 96 clocks; the design needs 60.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is driven and sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Sampled level of the shared wire (0 = low) |
| line_oe | output | 1 | 1 pulls the wire low; 0 releases it |
| quiet_mode | input | 1 | 1 requests Quiet mode for the next cycle; 0 requests Continuous |
| frame_count | input | $clog2(MAX_FRAMES+1) | Number of interrupt frames per cycle |
| irq_level | output | MAX_FRAMES | Latched request levels, 1 = asserted |
| irq_valid | output | 1 | One-clock strobe marking an `irq_level` update |

## Verification
Several request patterns are driven onto the frames:
- Alternating bits and a sparse pattern that touches the first and last frames tell a correct frame index from an off-by-one in the slot position.
- A cycle with 32 frames that sets the top bit, followed by a 20-frame cycle, shows whether stale bits above the frame count are cleared.
- A frame count of 5 shows that short counts are raised to 17.

Cycles are also opened in three ways, and each one's start and stop pulse widths are measured:
- by the host after reset;
- by a peripheral in Quiet mode;
- by the host after the quiet request is withdrawn.

Together these separate the effects of the mode register from those of the stop width.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_TURN,
    ST_FRAME,
    ST_STOP,
    ST_REC
  } sirq_state_e;

  // Host-opened start pulse length in clocks.
  localparam int unsigned HOST_LOW_CLKS  = 4;
  // Clocks the host adds after a one-clock peripheral start.
  localparam int unsigned EXT_LOW_CLKS   = 3;
  // Released clocks between start pulse and first frame.
  localparam int unsigned TURN_CLKS      = 2;
  // Stop widths selecting the next mode.
  localparam int unsigned STOP_QUIET     = 2;
  localparam int unsigned STOP_CONT      = 3;

endpackage

// File: rtl/sirq_count_clamp.sv
module sirq_count_clamp #(
  parameter int MAX_FRAMES = 32,
  parameter int MIN_FRAMES = 17,
  localparam int CNT_W = $clog2(MAX_FRAMES + 1)
) (
  input  logic [CNT_W-1:0] req,
  output logic [CNT_W-1:0] eff
);

  localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_FRAMES);
  localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_FRAMES);

  always_comb begin
    if (req < LO)      eff = LO;
    else if (req > HI) eff = HI;
    else               eff = req;
  end

endmodule

// File: rtl/sirq_sampler.sv
module sirq_sampler #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             sample_en,
  input  logic [IDX_W-1:0] idx,
  input  logic             line_in,
  input  logic             commit,
  output logic [N-1:0]     level,
  output logic             valid
);

  logic [N-1:0] shadow;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clear)
        shadow[g] <= 1'b0;
      else if (sample_en && (idx == IDX_W'(g)))
        shadow[g] <= ~line_in;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
      valid <= 1'b0;
    end else begin
      valid <= commit;
      if (commit) level <= shadow;
    end
  end

endmodule

// File: rtl/sirq_host.sv
module sirq_host
  import sirq_pkg::*;
#(
  parameter int MAX_FRAMES = 32,
  parameter int MIN_FRAMES = 17,
  localparam int CNT_W = $clog2(MAX_FRAMES + 1),
  localparam int IDX_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  line_in,
  output logic                  line_oe,
  input  logic                  quiet_mode,
  input  logic [CNT_W-1:0]      frame_count,
  output logic [MAX_FRAMES-1:0] irq_level,
  output logic                  irq_valid
);

  sirq_state_e      st;
  logic [2:0]       cnt;
  logic [1:0]       ph;
  logic [IDX_W-1:0] idx;
  logic [CNT_W-1:0] nfr_q;
  logic [CNT_W-1:0] nfr_eff;
  logic             quiet_q;
  logic             stop_quiet;

  logic host_go, periph_go, smp_en, open_cyc, commit, last_frame;

  sirq_count_clamp #(
    .MAX_FRAMES(MAX_FRAMES),
    .MIN_FRAMES(MIN_FRAMES)
  ) u_clamp (
    .req(frame_count),
    .eff(nfr_eff)
  );

  always_comb begin
    host_go    = (st == ST_IDLE) && (!quiet_q || !quiet_mode);
    periph_go  = (st == ST_IDLE) && quiet_q && quiet_mode && !line_in;
    open_cyc   = host_go || periph_go;
    smp_en     = (st == ST_FRAME) && (ph == 2'd0);
    commit     = (st == ST_STOP) && (cnt == 3'd0);
    last_frame = ((CNT_W'(idx) + CNT_W'(1)) == nfr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      ph         <= '0;
      idx        <= '0;
      nfr_q      <= CNT_W'(MIN_FRAMES);
      quiet_q    <= 1'b0;
      stop_quiet <= 1'b0;
      line_oe    <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (host_go) begin
            st      <= ST_START;
            cnt     <= 3'(HOST_LOW_CLKS - 1);
            line_oe <= 1'b1;
            nfr_q   <= nfr_eff;
          end else if (periph_go) begin
            st      <= ST_START;
            cnt     <= 3'(EXT_LOW_CLKS - 1);
            line_oe <= 1'b1;
            nfr_q   <= nfr_eff;
          end
        end
        ST_START: begin
          if (cnt == 3'd0) begin
            st      <= ST_TURN;
            cnt     <= 3'(TURN_CLKS - 1);
            line_oe <= 1'b0;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_TURN: begin
          if (cnt == 3'd0) begin
            st  <= ST_FRAME;
            idx <= '0;
            ph  <= '0;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_FRAME: begin
          if (ph == 2'd2) begin
            ph <= '0;
            if (last_frame) begin
              st         <= ST_STOP;
              line_oe    <= 1'b1;
              stop_quiet <= quiet_mode;
              cnt        <= quiet_mode ? 3'(STOP_QUIET - 1) : 3'(STOP_CONT - 1);
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end else begin
            ph <= ph + 2'd1;
          end
        end
        ST_STOP: begin
          if (cnt == 3'd0) begin
            st      <= ST_REC;
            line_oe <= 1'b0;
            quiet_q <= stop_quiet;
          end else begin
            cnt <= cnt - 3'd1;
          end
        end
        ST_REC:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  sirq_sampler #(.N(MAX_FRAMES)) u_sampler (
    .clk      (clk),
    .rst      (rst),
    .clear    (open_cyc),
    .sample_en(smp_en),
    .idx      (idx),
    .line_in  (line_in),
    .commit   (commit),
    .level    (irq_level),
    .valid    (irq_valid)
  );

endmodule

// File: rtl/sirq_host_chk.sv
module sirq_host_chk #(
  parameter int N = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         line_oe,
  input logic         irq_valid,
  input logic [N-1:0] irq_level
);

  logic [2:0] run;

  always_ff @(posedge clk) begin
    if (rst)          run <= '0;
    else if (line_oe) run <= (run == 3'd7) ? 3'd7 : run + 3'd1;
    else              run <= '0;
  end

  AST_RESET_RELEASE: assert property (@(posedge clk) $past(rst) |-> !line_oe); // R1

  AST_LOW_RUN_MAX: assert property (@(posedge clk) disable iff (rst)
    run <= 3'd4); // R2

  AST_RELEASE_GAP: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |=> !line_oe); // R6

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    irq_valid |=> !irq_valid); // R9

  AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
    !irq_valid |-> $stable(irq_level)); // R9

endmodule

bind sirq_host sirq_host_chk #(.N(MAX_FRAMES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .line_oe  (line_oe),
  .irq_valid(irq_valid),
  .irq_level(irq_level)
);

// File: tb/sirq_host_bench.sv
`timescale 1ns/1ps
module sirq_host_bench;

  localparam int MAXF  = 32;
  localparam int CNT_W = $clog2(MAXF + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             pdrive = 1'b0;
  logic             line_in;
  logic             line_oe;
  logic             quiet_mode = 1'b0;
  logic [CNT_W-1:0] frame_count = CNT_W'(17);
  logic [MAXF-1:0]  irq_level;
  logic             irq_valid;

  int  n_chk = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;

  always #10 clk = ~clk;

  // Open-drain wire: low if host or peripheral pulls it.
  assign line_in = ~(line_oe | pdrive);

  sirq_host #(.MAX_FRAMES(MAXF)) u_sirq_host (
    .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
    .quiet_mode(quiet_mode), .frame_count(frame_count),
    .irq_level(irq_level), .irq_valid(irq_valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One full bus cycle. Returns at the negedge of the clock after the strobe.
  task automatic do_cycle(input bit periph, input logic [31:0] pat, input int fc,
                          input bit q, input int exp_gap, input string tag);
    int n, k, waits, stopw, kv;
    bit start_ok;
    logic [31:0] expv, held;
    n = (fc < 17) ? 17 : ((fc > MAXF) ? MAXF : fc);
    expv = '0;
    for (int i = 0; i < n; i++) expv[i] = pat[i];
    frame_count = CNT_W'(fc);
    quiet_mode  = q;
    waits = 0; stopw = 0; start_ok = 1'b1; kv = -1;
    @(negedge clk);
    if (periph) pdrive = 1'b1;
    else while (!line_oe && waits < 500) begin waits++; @(negedge clk); end
    for (k = 0; k < 400; k++) begin
      if (k > 0) @(negedge clk);
      pdrive = (periph && k == 0) ||
               (k >= 6 && ((k - 6) % 3 == 0) && ((k - 6) / 3 < n) && pat[(k - 6) / 3]);
      if (k <= 3 && line_oe != (periph ? (k >= 1) : 1'b1)) start_ok = 1'b0;
      if (k == 4 && line_oe) start_ok = 1'b0;
      if (k >= 3 * n + 6 && line_oe) stopw++;
      if (irq_valid) begin kv = k; break; end
    end
    pdrive = 1'b0;
    if (periph) chk(start_ok, {"R7 peripheral start extended ", tag}, start_ok, 1);
    else        chk(start_ok, {"R2 host start width ", tag}, start_ok, 1);
    chk(stopw == (q ? 2 : 3), {"R5 stop width ", tag}, stopw, q ? 2 : 3);
    chk(kv == 3 * n + 6 + (q ? 2 : 3), {"R9 strobe clock ", tag}, kv, 3 * n + 6 + (q ? 2 : 3));
    chk(irq_level == expv, {"R3 R4 sampled vector ", tag}, irq_level, expv);
    if (n == 17 && !periph) chk(kv <= 96, {"R10 cycle length ", tag}, kv, 96);
    if (exp_gap >= 0) chk(waits == exp_gap, {"R6 restart gap ", tag}, waits, exp_gap);
    held = irq_level;
    @(negedge clk);
    chk(!irq_valid, {"R9 strobe one clock ", tag}, irq_valid, 0);
    chk(irq_level == held, {"R9 level held ", tag}, irq_level, held);
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(line_oe == 1'b0, "R1 wire released in reset", line_oe, 0);
    chk(irq_level == '0, "R1 levels cleared in reset", irq_level, 0);
    chk(irq_valid == 1'b0, "R1 strobe low in reset", irq_valid, 0);
    rst = 1'b0;
  endtask

  task automatic t_quiet_wait;
    bit quiet_ok = 1'b1;
    repeat (20) begin @(negedge clk); if (line_oe) quiet_ok = 1'b0; end
    chk(quiet_ok, "R7 host idle in quiet mode", quiet_ok, 1);
  endtask

  initial begin
    t_reset();
    // R1 first cycle opened by host; R10 17 frames
    do_cycle(1'b0, 32'h0001_5555, 17, 1'b0, -1, "first");
    // R6 continuous restart (gap 0 after the check clock); R4 count 5 raised to 17
    do_cycle(1'b0, 32'h0001_8421, 5, 1'b1, 0, "clamp-low");
    t_quiet_wait();
    // R7 peripheral-opened cycle with 32 frames, top bit set
    do_cycle(1'b1, 32'h8000_0081, 32, 1'b1, -1, "periph");
    t_quiet_wait();
    // R8 quiet request withdrawn: host opens cycle, wide stop follows
    do_cycle(1'b0, 32'h000F_F00F, 20, 1'b0, 0, "force-cont");
    // R4 count above max lowered; then R6 continuous again
    do_cycle(1'b0, 32'hFFFF_FFFF, 40, 1'b0, 0, "clamp-high");
    do_cycle(1'b0, 32'h0000_0000, 17, 1'b0, 0, "all-clear");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule